// File: doc/BRIEF.md
# Two-Stage Lane Min/Max Execution Unit

This unit executes one packed-operand min/max instruction per cycle. It takes a 64-bit instruction word and three 32-bit register values (A, B and C). First it picks the minimum or the maximum of A and B. Each of A and B can be a whole word, one halfword or one byte of its register, and each can be signed or unsigned on its own. The result of that first stage then goes to a second stage, which combines it with C. The second stage can write a halfword or a byte of the result into a slot of C, add it to C with optional clamping, take a further minimum or maximum against C with its own signedness, or pass the result through unchanged.

The opcode match and the unsupported flag are combinational, so the issuing logic sees them in the same cycle. The result and its valid strobe are registered and appear on the following clock edge. The register file, condition codes and immediate or constant operands belong to the surrounding pipeline.

Top module: `vmm_unit`

## Requirements
- R1: An issued word is accepted (`accept` high, same cycle) only when bits 63:57 equal 7'b0011101. For any other value, `accept` stays low, `res_valid` is low on the next edge and `result` keeps its value.
- R2: Bit 56 chooses the first stage: 1 gives max(A,B) and 0 gives min(A,B).
- R3: Bit 48 marks A as signed and bit 49 marks B as signed. Each operand is extended to 33 bits using only its own flag, and the two are then compared as signed 33-bit values, so mixed signedness is ordered correctly.
- R4: The A format is bits 38:37 and the B format is bits 30:29. The code 11 means a 32-bit word, 10 means a 16-bit halfword, and 00 or 01 mean an 8-bit byte. The A selector is bits 37:36 and the B selector is bits 29:28. A halfword is the upper one when selector bit 0 is 1, else the lower one. A byte index is the whole 2-bit selector, whose upper bit is the format's lower bit. The lane is sign-extended if its operand is signed and zero-extended otherwise.
- R5: Second-stage codes (bits 53:51) 0 to 3 merge bits of the first-stage result R into C. Code 0 puts R[15:0] into C[31:16]. Code 1 puts R[15:0] into C[15:0]. Code 2 puts R[7:0] into C[7:0]. Code 3 puts R[7:0] into C[23:16]. All other bits of C are kept.
- R6: Code 4 outputs R+C modulo 2^32 when bit 55 (saturate) is clear.
- R7: Code 5 outputs min(R,C) and code 6 outputs max(R,C). This comparison is signed when bit 54 is set and unsigned otherwise, whatever the first-stage flags are.
- R8: Code 7 outputs R unchanged.
- R9: With saturate set, code 4 clamps the sum to the range 0x80000000..0x7FFFFFFF when bit 54 is set, and to 0xFFFFFFFF at most when it is clear. Codes other than 4 ignore saturate.
- R10: An accepted word with bit 50 clear (B is not a register) raises `unsupported` in the same cycle. No result is written, `res_valid` is low on the next edge and `result` holds.
- R11: For an accepted word with bit 50 set, `result` and `res_valid` change on the next rising edge. With no such word, `result` holds its value.
- R12: A synchronous active-high reset clears `result` to 0 and `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 64 | Instruction word |
| src_a | input | 32 | Register operand A |
| src_b | input | 32 | Register operand B |
| src_c | input | 32 | Register operand C |
| accept | output | 1 | Opcode matched on an issued word (combinational) |
| unsupported | output | 1 | Accepted word asks for an immediate B (combinational) |
| res_valid | output | 1 | `result` was written on the last edge |
| result | output | 32 | Registered result |

## Verification
The bench goes after the operand pairs 0x80000000/0x7FFFFFFF and 0xFFFFFFFF/0 under every mix of the signedness flags. A unit that compared mixed-sign operands in plain 32-bit form would pick the wrong winner there. It also drives saturated additions that overflow in both directions, so a clamp with the wrong sign or a missing clamp shows up as a wrapped sum. Byte and halfword lane choices, including the byte index whose top bit comes from the format field, expose a wrong lane or a wrong extension. Merges into each slot of C catch a field placed at the wrong offset. Words with a near-miss opcode and words with an immediate B must leave `result` untouched.

// File: rtl/vmm_pkg.sv
package vmm_pkg;

    localparam int DW      = 32;
    localparam int XW      = DW + 1;
    localparam int IW      = 64;
    localparam int HW      = DW / 2;
    localparam int BW      = 8;
    localparam int NLANE_B = DW / BW;
    localparam int NSRC    = 2;

    localparam int OPC_HI = 63;
    localparam int OPC_LO = 57;
    localparam logic [OPC_HI-OPC_LO:0] OPC_VAL = 7'b0011101;

    localparam int BIT_MX    = 56;
    localparam int BIT_SAT   = 55;
    localparam int BIT_DSGN  = 54;
    localparam int CODE_HI   = 53;
    localparam int CODE_LO   = 51;
    localparam int BIT_BREG  = 50;
    localparam int BIT_BSGN  = 49;
    localparam int BIT_ASGN  = 48;
    localparam int FMTA_LO   = 37;
    localparam int SELA_LO   = 36;
    localparam int FMTB_LO   = 29;
    localparam int SELB_LO   = 28;

    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] UMAX = {DW{1'b1}};

    typedef enum logic [2:0] {
        S2_INS_HI16 = 3'd0,
        S2_INS_LO16 = 3'd1,
        S2_INS_B0   = 3'd2,
        S2_INS_B2   = 3'd3,
        S2_ADD      = 3'd4,
        S2_MIN      = 3'd5,
        S2_MAX      = 3'd6,
        S2_PASS     = 3'd7
    } s2_code_e;

    typedef enum logic [1:0] {
        LF_BYTE = 2'd0,
        LF_HALF = 2'd1,
        LF_WORD = 2'd2
    } lane_fmt_e;

    typedef struct packed {
        logic [DW-1:0] val;
        lane_fmt_e     fmt;
        logic [1:0]    sel;
        logic          sgn;
    } src_desc_t;

    typedef struct packed {
        logic       take_max;
        logic       a_sgn;
        logic       b_sgn;
        logic       d_sgn;
        logic       sat;
        logic       b_reg;
        lane_fmt_e  fmt_a;
        lane_fmt_e  fmt_b;
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        s2_code_e   code;
    } vmm_dec_t;

    function automatic lane_fmt_e fmt_of(input logic [1:0] f);
        case (f)
            2'b11:   return LF_WORD;
            2'b10:   return LF_HALF;
            default: return LF_BYTE;
        endcase
    endfunction

    function automatic logic lt_sel(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                    input logic sgn);
        if (sgn) return $signed(x) < $signed(y);
        return x < y;
    endfunction

    function automatic logic [DW-1:0] add_clamp(input logic [DW-1:0] x,
                                                input logic [DW-1:0] y,
                                                input logic sat, input logic sgn);
        logic [DW:0] sum;
        logic        ovf;
        sum = {1'b0, x} + {1'b0, y};
        if (!sat) return sum[DW-1:0];
        if (sgn) begin
            ovf = (x[DW-1] == y[DW-1]) && (sum[DW-1] != x[DW-1]);
            if (ovf) return x[DW-1] ? SMIN : SMAX;
            return sum[DW-1:0];
        end
        return sum[DW] ? UMAX : sum[DW-1:0];
    endfunction

endpackage

// File: rtl/vmm_decode.sv
module vmm_decode
    import vmm_pkg::*;
(
    input  logic          issue,
    input  logic [IW-1:0] instr,
    output vmm_dec_t      dec,
    output logic          hit,
    output logic          imm_b
);
    logic unused_bits;

    always_comb begin
        dec.take_max = instr[BIT_MX];
        dec.sat      = instr[BIT_SAT];
        dec.d_sgn    = instr[BIT_DSGN];
        dec.code     = s2_code_e'(instr[CODE_HI:CODE_LO]);
        dec.b_reg    = instr[BIT_BREG];
        dec.b_sgn    = instr[BIT_BSGN];
        dec.a_sgn    = instr[BIT_ASGN];
        dec.fmt_a    = fmt_of(instr[FMTA_LO+1:FMTA_LO]);
        dec.fmt_b    = fmt_of(instr[FMTB_LO+1:FMTB_LO]);
        dec.sel_a    = instr[SELA_LO+1:SELA_LO];
        dec.sel_b    = instr[SELB_LO+1:SELB_LO];
    end

    assign hit   = issue && (instr[OPC_HI:OPC_LO] == OPC_VAL);
    assign imm_b = hit && !instr[BIT_BREG];

    assign unused_bits = ^{instr[47:39], instr[35:31], instr[27:0]};
endmodule

// File: rtl/vmm_lane_extract.sv
module vmm_lane_extract
    import vmm_pkg::*;
(
    input  src_desc_t     src,
    output logic [XW-1:0] ext
);
    logic [HW-1:0] half;
    logic [BW-1:0] byte_v;

    always_comb begin
        half   = src.sel[0] ? src.val[DW-1:HW] : src.val[HW-1:0];
        byte_v = src.val[BW*src.sel +: BW];
        case (src.fmt)
            LF_WORD: ext = {src.sgn & src.val[DW-1], src.val};
            LF_HALF: ext = {{(XW-HW){src.sgn & half[HW-1]}}, half};
            default: ext = {{(XW-BW){src.sgn & byte_v[BW-1]}}, byte_v};
        endcase
    end
endmodule

// File: rtl/vmm_stage1.sv
module vmm_stage1
    import vmm_pkg::*;
(
    input  logic [XW-1:0] ext_a,
    input  logic [XW-1:0] ext_b,
    input  logic          take_max,
    output logic [DW-1:0] r1
);
    logic          a_lt_b;
    logic [XW-1:0] pick;
    logic          unused_top;

    always_comb begin
        a_lt_b = $signed(ext_a) < $signed(ext_b);
        if (take_max) pick = a_lt_b ? ext_b : ext_a;
        else          pick = a_lt_b ? ext_a : ext_b;
    end

    assign r1         = pick[DW-1:0];
    assign unused_top = pick[XW-1];
endmodule

// File: rtl/vmm_stage2.sv
module vmm_stage2
    import vmm_pkg::*;
(
    input  logic [DW-1:0] r1,
    input  logic [DW-1:0] opc,
    input  s2_code_e      code,
    input  logic          d_sgn,
    input  logic          sat,
    output logic [DW-1:0] res
);
    logic r_lt_c;

    always_comb begin
        r_lt_c = lt_sel(r1, opc, d_sgn);
        case (code)
            S2_INS_HI16: res = {r1[HW-1:0], opc[HW-1:0]};
            S2_INS_LO16: res = {opc[DW-1:HW], r1[HW-1:0]};
            S2_INS_B0:   res = {opc[DW-1:BW], r1[BW-1:0]};
            S2_INS_B2:   res = {opc[DW-1:HW+BW], r1[BW-1:0], opc[HW-1:0]};
            S2_ADD:      res = add_clamp(r1, opc, sat, d_sgn);
            S2_MIN:      res = r_lt_c ? r1 : opc;
            S2_MAX:      res = r_lt_c ? opc : r1;
            default:     res = r1;
        endcase
    end
endmodule

// File: rtl/vmm_unit.sv
module vmm_unit
    import vmm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [63:0]   instr,
    input  logic [31:0]   src_a,
    input  logic [31:0]   src_b,
    input  logic [31:0]   src_c,
    output logic          accept,
    output logic          unsupported,
    output logic          res_valid,
    output logic [31:0]   result
);
    vmm_dec_t      dec;
    logic          hit;
    logic          imm_b;
    src_desc_t     srcs [NSRC];
    logic [XW-1:0] exts [NSRC];
    logic [DW-1:0] r1;
    logic [DW-1:0] r2;
    logic          wr_en;

    vmm_decode u_dec (
        .issue (issue),
        .instr (instr),
        .dec   (dec),
        .hit   (hit),
        .imm_b (imm_b)
    );

    always_comb begin
        srcs[0] = '{val: src_a, fmt: dec.fmt_a, sel: dec.sel_a, sgn: dec.a_sgn};
        srcs[1] = '{val: src_b, fmt: dec.fmt_b, sel: dec.sel_b, sgn: dec.b_sgn};
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        vmm_lane_extract u_ext (
            .src (srcs[i]),
            .ext (exts[i])
        );
    end

    vmm_stage1 u_s1 (
        .ext_a    (exts[0]),
        .ext_b    (exts[1]),
        .take_max (dec.take_max),
        .r1       (r1)
    );

    vmm_stage2 u_s2 (
        .r1    (r1),
        .opc   (src_c),
        .code  (dec.code),
        .d_sgn (dec.d_sgn),
        .sat   (dec.sat),
        .res   (r2)
    );

    assign accept      = hit;
    assign unsupported = imm_b;
    assign wr_en       = hit && dec.b_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            result    <= '0;
        end else begin
            res_valid <= wr_en;
            if (wr_en) result <= r2;
        end
    end
endmodule

// File: rtl/vmm_chk.sv
module vmm_chk (
    input logic        clk,
    input logic        rst,
    input logic        issue,
    input logic [63:0] instr,
    input logic [31:0] src_a,
    input logic [31:0] src_b,
    input logic [31:0] src_c,
    input logic        accept,
    input logic        unsupported,
    input logic        res_valid,
    input logic [31:0] result
);
    // R1: no match, no result
    a_r1_nomatch_no_result: assert property (@(posedge clk) disable iff (rst)
        !(issue && instr[63:57] == 7'b0011101) |=> !res_valid);

    // R10: immediate-B word writes nothing
    a_r10_imm_no_write: assert property (@(posedge clk) disable iff (rst)
        unsupported |=> (!res_valid && $stable(result)));

    // R11: valid follows an accepted register-B word
    a_r11_valid_next: assert property (@(posedge clk) disable iff (rst)
        (accept && instr[50]) |=> res_valid);

    // R11: result holds without a write
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !(accept && instr[50]) |=> $stable(result));

    // R5: low-halfword merge keeps the top of C
    a_r5_keep_c_high: assert property (@(posedge clk) disable iff (rst)
        (accept && instr[50] && instr[53:51] == 3'd1) |=> result[31:16] == $past(src_c[31:16]));

    // R2: unsigned word max with pass-through
    a_r2_umax_pass: assert property (@(posedge clk) disable iff (rst)
        (accept && instr[50] && instr[53:51] == 3'd7 && instr[56] && !instr[48] && !instr[49]
         && instr[38:37] == 2'b11 && instr[30:29] == 2'b11)
        |=> result == (($past(src_a) > $past(src_b)) ? $past(src_a) : $past(src_b)));

    // R12: reset clears the outputs
    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (!res_valid && result == 32'd0));
endmodule

bind vmm_unit vmm_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue       (issue),
    .instr       (instr),
    .src_a       (src_a),
    .src_b       (src_b),
    .src_c       (src_c),
    .accept      (accept),
    .unsupported (unsupported),
    .res_valid   (res_valid),
    .result      (result)
);

// File: tb/tb_vmm_unit.sv
module tb_vmm_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [63:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] src_c = '0;
    logic        accept;
    logic        unsupported;
    logic        res_valid;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    vmm_unit dut (
        .clk         (clk),
        .rst         (rst),
        .issue       (issue),
        .instr       (instr),
        .src_a       (src_a),
        .src_b       (src_b),
        .src_c       (src_c),
        .accept      (accept),
        .unsupported (unsupported),
        .res_valid   (res_valid),
        .result      (result)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic        mx;
        logic        sa;
        logic        sb;
        logic        sd;
        logic        sat;
        logic [1:0]  fa;
        logic        s0a;
        logic [1:0]  fb;
        logic        s0b;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'h80000000, 32'h7FFFFFFF, 32'h0, 32'h7FFFFFFF, 8'd3}, // R3
        '{3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'h80000000, 32'h7FFFFFFF, 32'h0, 32'h80000000, 8'd3}, // R3
        '{3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'hFFFFFFFF, 32'h0, 32'h0, 32'hFFFFFFFF, 8'd3},        // R3
        '{3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 8'd2},               // R2
        '{3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'hFFFFFFFF, 32'h0, 32'h0, 32'hFFFFFFFF, 8'd2},        // R2
        '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'h00001234, 32'h56, 32'hAAAABBBB, 32'h1234BBBB, 8'd5}, // R5
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'h0001ABCD, 32'h0, 32'h11112222, 32'h1111ABCD, 8'd5},  // R5
        '{3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'h000001FF, 32'h0, 32'h11223344, 32'h112233FF, 8'd5},  // R5
        '{3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'h000000CD, 32'h1, 32'h11223344, 32'h11CD3344, 8'd5},  // R5
        '{3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'hFFFFFFF0, 32'h0, 32'h20, 32'h00000010, 8'd6},        // R6
        '{3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 2'b11, 1'b1, 32'hFFFFFFF0, 32'h0, 32'h20, 32'hFFFFFFFF, 8'd9},        // R9
        '{3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 2'b11, 1'b1, 32'h7FFFFFF0, 32'h0, 32'h10, 32'h7FFFFFFF, 8'd9},        // R9
        '{3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 2'b11, 1'b1, 32'h80000000, 32'h0, 32'hFFFFFFFF, 32'h80000000, 8'd9},  // R9
        '{3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'h5, 32'h3, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd7},         // R7
        '{3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'h5, 32'h3, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd7},         // R7
        '{3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 32'h5, 32'h3, 32'hFFFFFFFF, 32'h5, 8'd7},                // R7
        '{3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 2'b11, 1'b1, 32'h5, 32'h3, 32'h3, 32'h3, 8'd9},                       // R9
        '{3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 2'b11, 1'b1, 32'h80112233, 32'h0, 32'h0, 32'hFFFFFF80, 8'd4},         // R4
        '{3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 2'b10, 1'b0, 32'h80010000, 32'h00007FFF, 32'h0, 32'h00008001, 8'd4},  // R4
        '{3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 32'h12345699, 32'h0000AB00, 32'h0, 32'h000000AB, 8'd8}   // R8, R4
    };

    function automatic logic [63:0] mk(input logic [2:0] code, input logic mx, input logic sa,
                                       input logic sb, input logic sd, input logic sat,
                                       input logic [1:0] fa, input logic s0a,
                                       input logic [1:0] fb, input logic s0b, input logic breg);
        logic [63:0] w;
        w = '0;
        w[63:57] = 7'b0011101;
        w[56] = mx;    w[55] = sat;   w[54] = sd;
        w[53:51] = code;
        w[50] = breg;  w[49] = sb;    w[48] = sa;
        w[38:37] = fa; w[36] = s0a;
        w[30:29] = fb; w[28] = s0b;
        return w;
    endfunction

    function automatic longint lane_val(input logic [31:0] v, input logic [1:0] f,
                                        input logic [1:0] sel, input logic s);
        longint x;
        int     w;
        if (f == 2'b11) begin
            w = 32; x = longint'(v);
        end else if (f == 2'b10) begin
            w = 16; x = sel[0] ? longint'(v[31:16]) : longint'(v[15:0]);
        end else begin
            w = 8;  x = longint'((v >> (8 * sel)) & 32'hFF);
        end
        if (s && x[w-1]) x = x - (longint'(1) << w);
        return x;
    endfunction

    function automatic longint as_s32(input logic [31:0] v);
        return v[31] ? longint'(v) - (longint'(1) << 32) : longint'(v);
    endfunction

    function automatic logic [31:0] ref_out(input logic [63:0] w, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] c);
        longint      va, vb, r, t;
        logic [31:0] r32;
        va = lane_val(a, w[38:37], w[37:36], w[48]);
        vb = lane_val(b, w[30:29], w[29:28], w[49]);
        r  = w[56] ? ((va > vb) ? va : vb) : ((va < vb) ? va : vb);
        r32 = r[31:0];
        case (w[53:51])
            3'd0: return {r32[15:0], c[15:0]};
            3'd1: return {c[31:16], r32[15:0]};
            3'd2: return {c[31:8], r32[7:0]};
            3'd3: return {c[31:24], r32[7:0], c[15:0]};
            3'd4: begin
                if (!w[55]) return r32 + c;
                if (w[54]) begin
                    t = as_s32(r32) + as_s32(c);
                    if (t > 64'sd2147483647) return 32'h7FFFFFFF;
                    if (t < -64'sd2147483648) return 32'h80000000;
                    return t[31:0];
                end
                t = longint'(r32) + longint'(c);
                return (t > 64'sd4294967295) ? 32'hFFFFFFFF : t[31:0];
            end
            3'd5: return w[54] ? ((as_s32(r32) < as_s32(c)) ? r32 : c) : ((r32 < c) ? r32 : c);
            3'd6: return w[54] ? ((as_s32(r32) > as_s32(c)) ? r32 : c) : ((r32 > c) ? r32 : c);
            default: return r32;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive one word at a negedge; returns accept/unsupported seen that cycle.
    task automatic drive(input logic [63:0] w, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, output logic acc, output logic uns);
        @(negedge clk);
        issue = 1'b1; instr = w; src_a = a; src_b = b; src_c = c;
        #1;
        acc = accept; uns = unsupported;
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic run_expect(input string tag, input logic [63:0] w, input logic [31:0] a,
                              input logic [31:0] b, input logic [31:0] c, input logic [31:0] exp);
        logic acc, uns;
        drive(w, a, b, c, acc, uns);
        check({tag, " valid"}, {31'd0, res_valid}, 32'd1);
        check(tag, result, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        logic        acc, uns;
        logic [31:0] held;

        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset valid", {31'd0, res_valid}, 32'd0);
        check("R12 reset result", result, 32'd0);
        rst = 1'b0;

        // Table of directed vectors
        for (int i = 0; i < NV; i++) begin
            w = mk(TBL[i].code, TBL[i].mx, TBL[i].sa, TBL[i].sb, TBL[i].sd, TBL[i].sat,
                   TBL[i].fa, TBL[i].s0a, TBL[i].fb, TBL[i].s0b, 1'b1);
            run_expect($sformatf("R%0d vec%0d", TBL[i].req, i), w, TBL[i].a, TBL[i].b,
                       TBL[i].c, TBL[i].exp);
        end

        // Sweep: every second-stage code, sign flags, corner pairs, mx, sat
        for (int code = 0; code < 8; code++) begin
            for (int sg = 0; sg < 8; sg++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int m = 0; m < 2; m++) begin
                        for (int st = 0; st < 2; st++) begin
                            logic [31:0] a, b, c;
                            string tag;
                            a = p ? 32'hFFFFFFFF : 32'h80000000;
                            b = p ? 32'h00000000 : 32'h7FFFFFFF;
                            c = p ? 32'h00000001 : 32'h7FFFFFFF;
                            w = mk(3'(code), m[0], sg[0], sg[1], sg[2], st[0],
                                   2'b11, 1'b1, 2'b11, 1'b1, 1'b1);
                            case (code)
                                0, 1, 2, 3: tag = "R5 sweep";
                                4:          tag = st[0] ? "R9 sweep" : "R6 sweep";
                                5, 6:       tag = "R7 sweep";
                                default:    tag = "R8 sweep";
                            endcase
                            run_expect($sformatf("%s c%0d s%0d p%0d m%0d t%0d", tag, code, sg, p, m, st),
                                       w, a, b, c, ref_out(w, a, b, c));
                        end
                    end
                end
            end
        end

        // R1: near-miss opcode is rejected and leaves the result alone
        held = result;
        w = mk(3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 1'b1);
        w[63:57] = 7'b0011100;
        drive(w, 32'h1234, 32'h5678, 32'h0, acc, uns);
        check("R1 accept low", {31'd0, acc}, 32'd0);
        check("R1 no valid", {31'd0, res_valid}, 32'd0);
        check("R1 result held", result, held);

        // R1: matching word raises accept
        w = mk(3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 1'b1);
        drive(w, 32'h1234, 32'h5678, 32'h0, acc, uns);
        check("R1 accept high", {31'd0, acc}, 32'd1);
        check("R11 result next edge", result, 32'h5678);

        // R10: immediate B flagged, nothing written
        held = result;
        w = mk(3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 1'b0);
        drive(w, 32'h1, 32'h2, 32'h0, acc, uns);
        check("R10 unsupported", {31'd0, uns}, 32'd1);
        check("R10 no valid", {31'd0, res_valid}, 32'd0);
        check("R10 result held", result, held);

        // R11: idle cycle holds result and drops valid
        @(negedge clk);
        check("R11 idle valid low", {31'd0, res_valid}, 32'd0);
        check("R11 idle hold", result, held);

        // R12: reset after a write clears outputs
        w = mk(3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 2'b11, 1'b1, 1'b1);
        drive(w, 32'hCAFE0000, 32'h1, 32'h0, acc, uns);
        rst = 1'b1;
        @(negedge clk);
        check("R12 mid reset valid", {31'd0, res_valid}, 32'd0);
        check("R12 mid reset result", result, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule